// File: doc/BRIEF.md
# Six-Digit Time Display Scanner

This block turns a binary time of day (hours, minutes, seconds) into the drive signals for an eight-position common-anode seven-segment display. Each of the three fields is broken into a tens digit and a units digit. The six resulting decimal digits are shown one at a time, in turn, and each is held for a fixed number of clock cycles. The scan moves fast enough that all six appear lit at once.

Both output buses are active low. The segment bus carries seven segments plus a decimal point, and the decimal point is never lit. The digit-enable bus selects one of eight positions. Only six positions are used. Positions 2 and 5 stay dark, so a blank gap separates seconds from minutes and minutes from hours. The time inputs are read only when a digit slot begins. Both output buses are registered and load on the same edge, so segment and enable values always change together.

Top module: `hms_segment_scan`

## Requirements
- R1: While reset is asserted, both outputs read 8'hFF (nothing lit). The first clock edge after reset is released loads the seconds-units slot, and the scan restarts from that slot after any later reset.
- R2: The digit shown in each slot is computed from the field value: units = value mod 10 and tens = value div 10.
- R3: Segment patterns are active low, with bit 7 as the decimal point held at 1. Digits 0 to 9 map to 8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99, 8'h92, 8'h82, 8'hF8, 8'h80, 8'h90.
- R4: Slots run in this fixed order and then repeat: seconds units (dig_n 8'hFE), seconds tens (8'hFD), minutes units (8'hF7), minutes tens (8'hEF), hours units (8'hBF), hours tens (8'h7F). Bits 2 and 5 of dig_n are never driven low.
- R5: Each slot lasts exactly DWELL clock cycles. The outputs change only one cycle after a slot begins and stay constant for the rest of that slot.
- R6: The time inputs are sampled only on the clock edge that begins a slot. A change during a slot has no effect on the outputs until the next slot begins.
- R7: Outside reset and after the first slot has loaded, exactly one dig_n bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hours | input | HOUR_W (5) | Binary hours, 0 to 23 |
| minutes | input | MINSEC_W (6) | Binary minutes, 0 to 59 |
| seconds | input | MINSEC_W (6) | Binary seconds, 0 to 59 |
| seg_n | output | 8 | Segment drive, active low, bit 7 = decimal point |
| dig_n | output | 8 | Digit position enables, active low |

## Verification
The bench runs with a short dwell. Over 360 slots it steps the seconds through every value 0 to 59 in every one of the six slots, and moves minutes and hours with step sizes that cover their full ranges. This separates a wrong tens/units split or a wrong glyph from a wrong slot order. During every slot, on each cycle other than the one just before a slot boundary, the inputs are replaced with unrelated values. A design that reads its inputs outside the slot boundary, or that updates its outputs in the middle of a slot, therefore shows a wrong digit. A reset in the middle of a run checks that the outputs blank and that the scan restarts from the seconds-units slot.

// File: rtl/hms_scan_pkg.sv
package hms_scan_pkg;

    localparam int          SLOT_COUNT = 6;
    localparam int          POS_COUNT  = 8;
    localparam logic [7:0]  ALL_DARK   = 8'hFF;

    typedef enum logic [2:0] {
        SLOT_SEC_U = 3'd0,
        SLOT_SEC_T = 3'd1,
        SLOT_MIN_U = 3'd2,
        SLOT_MIN_T = 3'd3,
        SLOT_HR_U  = 3'd4,
        SLOT_HR_T  = 3'd5
    } scan_slot_e;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd_pair_t;

    typedef struct packed {
        logic [7:0] seg_n;
        logic [7:0] dig_n;
    } drive_t;

    // Active-low glyph for one decimal digit; decimal point (bit 7) stays dark.
    function automatic logic [7:0] glyph(input logic [3:0] d);
        logic [7:0] g;
        case (d)
            4'd0:    g = 8'hC0;
            4'd1:    g = 8'hF9;
            4'd2:    g = 8'hA4;
            4'd3:    g = 8'hB0;
            4'd4:    g = 8'h99;
            4'd5:    g = 8'h92;
            4'd6:    g = 8'h82;
            4'd7:    g = 8'hF8;
            4'd8:    g = 8'h80;
            4'd9:    g = 8'h90;
            default: g = ALL_DARK;
        endcase
        return g;
    endfunction

    // Physical display position used by each slot; 2 and 5 are separators.
    function automatic logic [2:0] slot_position(input scan_slot_e s);
        logic [2:0] p;
        case (s)
            SLOT_SEC_U: p = 3'd0;
            SLOT_SEC_T: p = 3'd1;
            SLOT_MIN_U: p = 3'd3;
            SLOT_MIN_T: p = 3'd4;
            SLOT_HR_U:  p = 3'd6;
            SLOT_HR_T:  p = 3'd7;
            default:    p = 3'd0;
        endcase
        return p;
    endfunction

    function automatic logic [7:0] slot_enable(input scan_slot_e s);
        logic [7:0] e;
        case (s)
            SLOT_SEC_U, SLOT_SEC_T, SLOT_MIN_U,
            SLOT_MIN_T, SLOT_HR_U, SLOT_HR_T:
                e = ~(8'(1) << slot_position(s));
            default:
                e = ALL_DARK;
        endcase
        return e;
    endfunction

    function automatic scan_slot_e slot_after(input scan_slot_e s);
        scan_slot_e n;
        case (s)
            SLOT_SEC_U: n = SLOT_SEC_T;
            SLOT_SEC_T: n = SLOT_MIN_U;
            SLOT_MIN_U: n = SLOT_MIN_T;
            SLOT_MIN_T: n = SLOT_HR_U;
            SLOT_HR_U:  n = SLOT_HR_T;
            default:    n = SLOT_SEC_U;
        endcase
        return n;
    endfunction

    // Expected successor of an enable pattern (used by the checker).
    function automatic logic [7:0] enable_after(input logic [7:0] en);
        logic [7:0] n;
        case (en)
            8'hFE:   n = 8'hFD;
            8'hFD:   n = 8'hF7;
            8'hF7:   n = 8'hEF;
            8'hEF:   n = 8'hBF;
            8'hBF:   n = 8'h7F;
            8'h7F:   n = 8'hFE;
            default: n = ALL_DARK;
        endcase
        return n;
    endfunction

    function automatic logic is_glyph(input logic [7:0] s);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (glyph(4'(i)) == s) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/hms_bcd_split.sv
module hms_bcd_split
    import hms_scan_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] value,
    output bcd_pair_t    digits
);

    always_comb begin
        digits.tens  = 4'(value / W'(10));
        digits.units = 4'(value % W'(10));
    end

endmodule

// File: rtl/hms_dwell_timer.sv
module hms_dwell_timer #(
    parameter int DWELL = 250000
) (
    input  logic clk,
    input  logic rst,
    output logic slot_start,
    output logic slot_end
);

    localparam int            CW   = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign slot_start = (cnt == '0);
    assign slot_end   = (cnt == LAST);

endmodule

// File: rtl/hms_scan_fsm.sv
module hms_scan_fsm
    import hms_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    output scan_slot_e slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOT_SEC_U;
        end else if (advance) begin
            slot <= slot_after(slot);
        end
    end

endmodule

// File: rtl/hms_digit_select.sv
module hms_digit_select
    import hms_scan_pkg::*;
(
    input  scan_slot_e          slot,
    input  bcd_pair_t [2:0]     fields,
    output drive_t              drive
);

    logic [3:0] digit;
    logic [7:0] enable;

    always_comb begin
        enable = slot_enable(slot);
        case (slot)
            SLOT_SEC_U: digit = fields[0].units;
            SLOT_SEC_T: digit = fields[0].tens;
            SLOT_MIN_U: digit = fields[1].units;
            SLOT_MIN_T: digit = fields[1].tens;
            SLOT_HR_U:  digit = fields[2].units;
            SLOT_HR_T:  digit = fields[2].tens;
            default: begin
                digit  = 4'd0;
                enable = ALL_DARK;
            end
        endcase
        drive.seg_n = glyph(digit);
        drive.dig_n = enable;
    end

endmodule

// File: rtl/hms_segment_scan.sv
module hms_segment_scan
    import hms_scan_pkg::*;
#(
    parameter int DWELL    = 250000,
    parameter int HOUR_W   = 5,
    parameter int MINSEC_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HOUR_W-1:0]   hours,
    input  logic [MINSEC_W-1:0] minutes,
    input  logic [MINSEC_W-1:0] seconds,
    output logic [7:0]          seg_n,
    output logic [7:0]          dig_n
);

    localparam int FIELDS  = 3;
    localparam int FIELD_W = (HOUR_W > MINSEC_W) ? HOUR_W : MINSEC_W;

    logic [FIELDS-1:0][FIELD_W-1:0] field_bin;
    bcd_pair_t [FIELDS-1:0]         field_bcd;
    logic                           slot_start;
    logic                           slot_end;
    scan_slot_e                     slot;
    drive_t                         drive_next;
    drive_t                         drive_q;

    assign field_bin[0] = FIELD_W'(seconds);
    assign field_bin[1] = FIELD_W'(minutes);
    assign field_bin[2] = FIELD_W'(hours);

    for (genvar g = 0; g < FIELDS; g++) begin : g_split
        hms_bcd_split #(.W(FIELD_W)) u_split (
            .value  (field_bin[g]),
            .digits (field_bcd[g])
        );
    end

    hms_dwell_timer #(.DWELL(DWELL)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .slot_start (slot_start),
        .slot_end   (slot_end)
    );

    hms_scan_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .advance (slot_end),
        .slot    (slot)
    );

    hms_digit_select u_select (
        .slot   (slot),
        .fields (field_bcd),
        .drive  (drive_next)
    );

    // Segment and enable buses load together, once per slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= '{seg_n: ALL_DARK, dig_n: ALL_DARK};
        end else if (slot_start) begin
            drive_q <= drive_next;
        end
    end

    assign seg_n = drive_q.seg_n;
    assign dig_n = drive_q.dig_n;

endmodule

// File: rtl/hms_segment_scan_chk.sv
module hms_segment_scan_chk
    import hms_scan_pkg::*;
#(
    parameter int DWELL = 250000
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] seg_n,
    input logic [7:0] dig_n
);

    localparam int            CW   = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0] phase;
    logic          rst_d;
    logic          loaded;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            phase  <= '0;
            loaded <= 1'b0;
        end else begin
            phase  <= (phase == LAST) ? '0 : phase + 1'b1;
            loaded <= 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_d) begin
            AST_RESET_DARK: assert (seg_n == ALL_DARK && dig_n == ALL_DARK); // R1
        end
    end

    AST_POINT_DARK: assert property (@(posedge clk) disable iff (rst)
        seg_n[7] == 1'b1); // R3

    AST_GLYPH_VALID: assert property (@(posedge clk) disable iff (rst)
        (loaded && dig_n != ALL_DARK) |-> is_glyph(seg_n)); // R3

    AST_GAP_DARK: assert property (@(posedge clk) disable iff (rst)
        dig_n[2] && dig_n[5]); // R4

    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (loaded && $past(dig_n) != ALL_DARK && dig_n != $past(dig_n))
            |-> dig_n == enable_after($past(dig_n))); // R4

    AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (rst)
        (loaded && $past(dig_n) == ALL_DARK && dig_n != ALL_DARK)
            |-> dig_n == 8'hFE); // R1

    AST_HOLD_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (phase != CW'(1) || DWELL == 1) |-> ($stable(seg_n) && $stable(dig_n)) || DWELL == 1); // R5

    AST_ONE_POSITION: assert property (@(posedge clk) disable iff (rst)
        $countones(~dig_n) <= 1); // R7

endmodule

bind hms_segment_scan hms_segment_scan_chk #(.DWELL(DWELL)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .seg_n (seg_n),
    .dig_n (dig_n)
);

// File: tb/hms_segment_scan_test.sv
`timescale 1ns/1ps
module hms_segment_scan_test;

    localparam int DWELL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] hours = '0;
    logic [5:0] minutes = '0;
    logic [5:0] seconds = '0;
    logic [7:0] seg_n;
    logic [7:0] dig_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_seg;
    logic [7:0] exp_dig;

    always #2.5 clk = ~clk;

    hms_segment_scan #(.DWELL(DWELL)) uut (
        .clk     (clk),
        .rst     (rst),
        .hours   (hours),
        .minutes (minutes),
        .seconds (seconds),
        .seg_n   (seg_n),
        .dig_n   (dig_n)
    );

    function automatic logic [7:0] ref_glyph(input int d);
        case (d)
            0: return 8'hC0;  1: return 8'hF9;  2: return 8'hA4;
            3: return 8'hB0;  4: return 8'h99;  5: return 8'h92;
            6: return 8'h82;  7: return 8'hF8;  8: return 8'h80;
            9: return 8'h90;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive the values the design must pick up at a slot boundary.
    task automatic drive_real(input int n);
        int m;
        m = n / 6;
        seconds = 6'(m % 60);
        minutes = 6'((m * 7 + 1) % 60);
        hours   = 5'((m * 5) % 24);
    endtask

    // Values driven in the middle of a slot; they must be ignored.
    task automatic drive_noise(input int e);
        seconds = 6'((e * 13 + 5) % 60);
        minutes = 6'((e * 17 + 2) % 60);
        hours   = 5'((e * 3 + 7) % 24);
    endtask

    task automatic load_expect(input int n);
        int st;
        int dv;
        int pos;
        st = n % 6;
        case (st)
            0: dv = seconds % 10;
            1: dv = seconds / 10;
            2: dv = minutes % 10;
            3: dv = minutes / 10;
            4: dv = hours % 10;
            default: dv = hours / 10;
        endcase
        pos = st + ((st >= 2) ? 1 : 0) + ((st >= 4) ? 1 : 0);
        exp_seg = ref_glyph(dv);
        exp_dig = ~(8'(1) << pos);
    endtask

    // Runs 'slots' slots after reset release; edge numbering starts at 1.
    task automatic run_slots(input int slots);
        drive_real(0);
        @(negedge clk);
        rst = 1'b0;
        for (int e = 1; e <= slots * DWELL; e++) begin
            @(posedge clk);
            @(negedge clk);
            if ((e - 1) % DWELL == 0) begin
                load_expect((e - 1) / DWELL);
                if (e == 1) begin
                    check8("R1 first slot enable", dig_n, 8'hFE);
                end
                check8("R2 digit glyph at slot start", seg_n, exp_seg);
                check8("R4 slot enable pattern", dig_n, exp_dig);
            end else begin
                check8("R6 glyph held despite input change", seg_n, exp_seg);
                check8("R5 enable held within slot", dig_n, exp_dig);
            end
            check8("R3 decimal point dark", {7'd0, seg_n[7]}, 8'd1);
            check8("R4 separator positions dark", {6'd0, dig_n[5], dig_n[2]}, 8'd3);
            check8("R7 single position lit", 8'($countones(~dig_n)), 8'd1);
            if (e % DWELL == 0) drive_real(e / DWELL);
            else                drive_noise(e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check8("R1 reset segments dark", seg_n, 8'hFF);
        check8("R1 reset enables dark", dig_n, 8'hFF);
        run_slots(360);

        // Reset in the middle of a slot.
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check8("R1 mid-run reset segments dark", seg_n, 8'hFF);
        check8("R1 mid-run reset enables dark", dig_n, 8'hFF);
        run_slots(14);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule